// File: doc/BRIEF.md
# Dadda-Tree Significand Multiplier

This block is the unsigned significand multiplier of a single-precision floating-point unit. It takes two 24-bit significands (hidden bit included) and returns their full 48-bit product in the same cycle. It has no registers. Normalisation, exponent arithmetic and rounding sit in neighbouring blocks, which read the product bits they need.

The block works in three phases. In the first, each bit of operand B either passes operand A into its row of the partial-product matrix or blanks the row. A row is a copy of A weighted by the bit's position, not a bank of AND gates. In the second, the columns of that matrix are compressed with full and half adders in a chain of stages. The stage limits follow the series 2, 3, 4, 6, 9, 13, 19, ..., where each term is the floor of 1.5 times the one before. Each stage adds only the adders needed to bring every column down to its limit, taking carries that arrive from the column below into account. In the third phase, the two rows that remain are summed by a carry-propagate adder.

The stage count, the limits and the adder count of every column are worked out at elaboration from the operand width. The same code therefore builds trees of other sizes.

Top module: `sigmul_dadda`

## Requirements
- R1: Partial-product row i carries operand A at weight 2^i when bit i of operand B is 1, and is all zeros when bit i of B is 0. A single-bit B = 2^i therefore gives a product of A shifted left by i.
- R2: `product` equals the exact unsigned product of `op_a` and `op_b` over all 48 bits, with no truncation.
- R3: Reduction runs one stage per height limit smaller than the operand width. For 24-bit operands these are the limits 19, 13, 9, 6, 4, 3, 2, in that order, seven stages in all. After each stage no column holds more than that stage's limit, and after the last no column holds more than two bits.
- R4: Every reduction stage preserves the weighted sum of its column bits, where a bit in column c counts 2^c.
- R5: The final carry-propagate addition of the two remaining rows produces no carry beyond bit 47. The top bit of the product is reachable: it is set for all-ones operands.
- R6: A zero on either operand gives a zero product whatever the other operand holds.
- R7: All-ones operands (0xFFFFFF times 0xFFFFFF) give 0xFFFFFE000001. This case fills every column to its maximum height.
- R8: Operands 2^i and 2^j give a product with exactly bit i+j set, for every i and j from 0 to 23.
- R9: Swapping the operands leaves the product unchanged.
- R10: The block is purely combinational. The product is valid in the same cycle in which the operands are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 24 | Multiplicand significand, unsigned |
| op_b | input | 24 | Multiplier significand, unsigned; each bit selects one partial-product row |
| product | output | 48 | Full unsigned product op_a * op_b |

## Verification
The assertions are evaluated whenever any input changes. They check the structure of the tree:
- every partial-product row is blank exactly when its selecting bit of B or all of A is zero;
- each reduction stage keeps the weighted sum of its bits, and no column rises above the stage limit;
- the adder input holds only two rows and gives no carry out;
- the product matches the exact multiply.

Only the bench scenarios show the corner values at the ports: the all-ones fill with its top bit set, every single-bit pairing, zero on either side, and operand swaps.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;

    // Upper bound on product columns handled by the elaboration planner.
    localparam int MAX_COLS = 128;

    // Which quantity the reduction planner should report.
    typedef enum logic [1:0] {
        Q_HEIGHT = 2'd0,   // column height after the given stage
        Q_FULL   = 2'd1,   // full adders placed in the column in the given stage
        Q_HALF   = 2'd2    // half adders placed in the column in the given stage
    } plan_q_e;

    // k-th term of the height-limit series, with term 1 equal to 2.
    function automatic int limit_at(input int k);
        int d;
        d = 2;
        for (int i = 1; i < k; i++) begin
            d = (d * 3) / 2;
        end
        return d;
    endfunction

    // Number of limits smaller than the tallest column (the operand width).
    function automatic int stage_count(input int n);
        int s;
        int d;
        s = 0;
        d = 2;
        while (d < n) begin
            s++;
            d = (d * 3) / 2;
        end
        return s;
    endfunction

    // Height of column c of the raw partial-product matrix.
    function automatic int init_height(input int n, input int c);
        if (c < n)          return c + 1;
        else if (c < 2*n-1) return 2*n - 1 - c;
        else                return 0;
    endfunction

    // Reduction planner. Stage numbers run from 1 (first, largest limit).
    // With Q_HEIGHT the result is the height of column col after `stage`
    // stages (stage 0 is the raw matrix). Otherwise it is the adder count
    // placed in column col during `stage`.
    function automatic int reduce_plan(input int n, input int stage,
                                       input int col, input plan_q_e q);
        int h [MAX_COLS];
        int w;
        int total;
        int lim;
        int cin;
        int ex;
        int fa;
        int ha;
        w     = 2 * n;
        total = stage_count(n);
        for (int c = 0; c < MAX_COLS; c++) begin
            h[c] = (c < w) ? init_height(n, c) : 0;
        end
        for (int t = 1; t <= stage; t++) begin
            lim = limit_at(total - t + 1);
            cin = 0;
            for (int c = 0; c < w; c++) begin
                ex = h[c] + cin - lim;
                if (ex > 0) begin
                    fa = ex / 2;
                    ha = ex % 2;
                end else begin
                    fa = 0;
                    ha = 0;
                end
                if (t == stage && c == col && q != Q_HEIGHT) begin
                    return (q == Q_FULL) ? fa : ha;
                end
                h[c] = h[c] - 2*fa - ha + cin;
                cin  = fa + ha;
            end
        end
        if (q != Q_HEIGHT) return 0;
        return h[col];
    endfunction

endpackage

// File: rtl/sigmul_pp_gen.sv
module sigmul_pp_gen
    import sigmul_pkg::*;
#(
    parameter int OP_W = 24
) (
    input  logic [OP_W-1:0]                 op_a,
    input  logic [OP_W-1:0]                 op_b,
    output logic [2*OP_W-1:0][OP_W-1:0]     pp_cols
);
    localparam int PROD_W = 2 * OP_W;

    // Row i: either a copy of A (weight 2^i implied by its column) or blank.
    logic [OP_W-1:0][OP_W-1:0] rows;

    for (genvar i = 0; i < OP_W; i++) begin : g_row
        assign rows[i] = op_b[i] ? op_a : '0;
    end

    // Stack rows into columns: column c holds rows LO..HI, bottom first.
    for (genvar c = 0; c < PROD_W; c++) begin : g_col
        localparam int LO = (c < OP_W) ? 0 : c - OP_W + 1;
        localparam int HI = (c < OP_W) ? c : OP_W - 1;
        for (genvar k = 0; k < OP_W; k++) begin : g_pos
            if (LO + k <= HI) begin : g_bit
                assign pp_cols[c][k] = rows[LO+k][c-LO-k];
            end else begin : g_pad
                assign pp_cols[c][k] = 1'b0;
            end
        end
    end

    // R1: a row is blank exactly when its selector bit or all of A is zero.
    always_comb begin
        for (int i = 0; i < OP_W; i++) begin
            assert_pp_row_R1: assert ((rows[i] == '0) == ((op_b[i] == 1'b0) || (op_a == '0)))
                else $error("pp row %0d inconsistent with selector", i);
        end
    end

endmodule

// File: rtl/sigmul_dadda_stage.sv
module sigmul_dadda_stage
    import sigmul_pkg::*;
#(
    parameter int OP_W  = 24,
    parameter int STAGE = 1
) (
    input  logic [2*OP_W-1:0][OP_W-1:0] in_cols,
    output logic [2*OP_W-1:0][OP_W-1:0] out_cols
);
    localparam int PROD_W  = 2 * OP_W;
    localparam int N_STAGE = stage_count(OP_W);
    localparam int LIMIT   = limit_at(N_STAGE - STAGE + 1);

    // Carries leaving each column in this stage, read by the next column.
    logic [PROD_W-1:0][OP_W-1:0] cy_all;

    for (genvar c = 0; c < PROD_W; c++) begin : g_col
        localparam int H_IN   = reduce_plan(OP_W, STAGE - 1, c, Q_HEIGHT);
        localparam int N_FA   = reduce_plan(OP_W, STAGE, c, Q_FULL);
        localparam int N_HA   = reduce_plan(OP_W, STAGE, c, Q_HALF);
        localparam int N_PASS = H_IN - 3*N_FA - 2*N_HA;
        localparam int N_CIN  = (c == 0) ? 0 :
                                reduce_plan(OP_W, STAGE, c - 1, Q_FULL) +
                                reduce_plan(OP_W, STAGE, c - 1, Q_HALF);
        localparam int CY_W   = (N_FA + N_HA > 0) ? N_FA + N_HA : 1;

        logic [CY_W-1:0] cy;
        logic [OP_W-1:0] col_nxt;
        logic [OP_W-1:0] cin_bits;

        if (c == 0) begin : g_nocin
            assign cin_bits = '0;
        end else begin : g_cin
            assign cin_bits = cy_all[c-1];
        end

        always_comb begin
            col_nxt = '0;
            cy      = '0;
            // untouched bits move to the bottom of the column
            for (int p = 0; p < N_PASS; p++) begin
                col_nxt[p] = in_cols[c][3*N_FA + 2*N_HA + p];
            end
            // full adders: three bits in, sum stays, carry moves up
            for (int f = 0; f < N_FA; f++) begin
                {cy[f], col_nxt[N_PASS+f]} = 2'(in_cols[c][3*f])
                                           + 2'(in_cols[c][3*f+1])
                                           + 2'(in_cols[c][3*f+2]);
            end
            // half adders: two bits in
            for (int g = 0; g < N_HA; g++) begin
                {cy[N_FA+g], col_nxt[N_PASS+N_FA+g]} = 2'(in_cols[c][3*N_FA+2*g])
                                                     + 2'(in_cols[c][3*N_FA+2*g+1]);
            end
            // carries arriving from the column below
            for (int k = 0; k < N_CIN; k++) begin
                col_nxt[N_PASS+N_FA+N_HA+k] = cin_bits[k];
            end
        end

        assign cy_all[c]   = OP_W'(cy);
        assign out_cols[c] = col_nxt;
    end

    // Weighted value of a column matrix (bit k of column c counts 2^c).
    function automatic logic [PROD_W-1:0] col_value(input logic [PROD_W-1:0][OP_W-1:0] m);
        logic [PROD_W-1:0] acc;
        acc = '0;
        for (int c = 0; c < PROD_W; c++) begin
            for (int k = 0; k < OP_W; k++) begin
                acc = acc + (PROD_W'(m[c][k]) << c);
            end
        end
        return acc;
    endfunction

    always_comb begin
        // R4: compression must not change the represented number
        assert_stage_sum_R4: assert (col_value(out_cols) == col_value(in_cols))
            else $error("stage %0d changed the column sum", STAGE);
        // R3: no column above this stage's limit
        for (int c = 0; c < PROD_W; c++) begin
            assert_stage_height_R3: assert ((out_cols[c] >> LIMIT) == '0)
                else $error("stage %0d column %0d exceeds limit %0d", STAGE, c, LIMIT);
        end
    end

endmodule

// File: rtl/sigmul_cpa.sv
module sigmul_cpa
    import sigmul_pkg::*;
#(
    parameter int OP_W = 24
) (
    input  logic [2*OP_W-1:0][OP_W-1:0] red_cols,
    output logic [2*OP_W-1:0]           sum
);
    localparam int PROD_W = 2 * OP_W;

    logic [PROD_W-1:0] row_lo;
    logic [PROD_W-1:0] row_hi;
    logic              carry_out;

    for (genvar c = 0; c < PROD_W; c++) begin : g_split
        assign row_lo[c] = red_cols[c][0];
        assign row_hi[c] = red_cols[c][1];
    end

    assign {carry_out, sum} = {1'b0, row_lo} + {1'b0, row_hi};

    always_comb begin
        // R3: reduction must leave at most two bits per column
        for (int c = 0; c < PROD_W; c++) begin
            assert_two_rows_R3: assert ((red_cols[c] >> 2) == '0)
                else $error("column %0d still taller than two", c);
        end
        // R5: the final addition fits the product width
        assert_no_carry_out_R5: assert (!carry_out)
            else $error("carry out of final adder");
    end

endmodule

// File: rtl/sigmul_dadda.sv
module sigmul_dadda
    import sigmul_pkg::*;
#(
    parameter int OP_W = 24
) (
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [2*OP_W-1:0] product
);
    localparam int PROD_W   = 2 * OP_W;
    localparam int N_STAGES = stage_count(OP_W);

    // Column matrix entering each stage; index N_STAGES holds two rows.
    logic [PROD_W-1:0][OP_W-1:0] cols [N_STAGES+1];

    sigmul_pp_gen #(.OP_W(OP_W)) u_pp (
        .op_a    (op_a),
        .op_b    (op_b),
        .pp_cols (cols[0])
    );

    for (genvar s = 1; s <= N_STAGES; s++) begin : g_stage
        sigmul_dadda_stage #(.OP_W(OP_W), .STAGE(s)) u_stage (
            .in_cols  (cols[s-1]),
            .out_cols (cols[s])
        );
    end

    sigmul_cpa #(.OP_W(OP_W)) u_cpa (
        .red_cols (cols[N_STAGES]),
        .sum      (product)
    );

    // R2: the tree must reproduce the exact unsigned product
    always_comb begin
        assert_exact_product_R2: assert (product == ({{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b}))
            else $error("product mismatch");
    end

endmodule

// File: tb/test_sigmul_dadda.sv
module test_sigmul_dadda;
    localparam int CLK_PERIOD = 10;
    localparam int OP_W       = 24;
    localparam int PROD_W     = 2 * OP_W;
    localparam int N_RANDOM   = 3000;

    typedef struct {
        logic [OP_W-1:0]   a;
        logic [OP_W-1:0]   b;
        logic [PROD_W-1:0] exp;
        string             tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [OP_W-1:0]   op_a = '0;
    logic [OP_W-1:0]   op_b = '0;
    logic [PROD_W-1:0] product;

    item_t sb_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    sigmul_dadda #(.OP_W(OP_W)) i_sigmul_dadda (
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [PROD_W-1:0] ref_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        longint unsigned p;
        p = longint'(a) * longint'(b);
        return p[PROD_W-1:0];
    endfunction

    task automatic check(input string tag, input logic [PROD_W-1:0] act, input logic [PROD_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present operands at a rising edge and queue the expectation.
    task automatic drive(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                         input logic [PROD_W-1:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        op_a <= a;
        op_b <= b;
        it.a = a; it.b = b; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: half a period later the combinational product must be there (R10).
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, product, it.exp);
        end
    end

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset-state zero operands", product, '0);
        @(posedge clk);
        rst <= 1'b0;

        // R7 / R5 / R3: all-ones fills every column; top bit is set
        drive('1, '1, 48'hFFFF_FE00_0001, "R7 all-ones");
        drive('1, '1, 48'hFFFF_FE00_0001, "R5 top bit reachable");

        // R6: zero on either side
        drive('0, '1, '0, "R6 zero A");
        drive('1, '0, '0, "R6 zero B");
        drive('0, '0, '0, "R6 both zero");
        drive(24'hA5C3_7E, '0, '0, "R6 zero B pattern A");

        // R1: single selector bit in B copies A shifted by i
        for (int i = 0; i < OP_W; i++) begin
            a = $urandom();
            drive(a, OP_W'(1) << i, PROD_W'(a) << i, "R1 single row");
        end

        // R8: every single-bit pairing
        for (int i = 0; i < OP_W; i++) begin
            for (int j = 0; j < OP_W; j++) begin
                drive(OP_W'(1) << i, OP_W'(1) << j, PROD_W'(1) << (i + j), "R8 single bits");
            end
        end

        // R2 / R4 / R9: random operands and their swaps
        for (int n = 0; n < N_RANDOM; n++) begin
            a = $urandom();
            b = $urandom();
            drive(a, b, ref_mul(a, b), "R2 random exact");
            if (n % 4 == 0) drive(b, a, ref_mul(a, b), "R9 swapped");
        end

        // R4 / R10: hidden-bit significands as seen by the float unit
        for (int n = 0; n < 200; n++) begin
            a = $urandom() | 24'h80_0000;
            b = $urandom() | 24'h80_0000;
            drive(a, b, ref_mul(a, b), "R4 normalised operands");
        end
        drive(24'hCC_CCCD, 24'h9B_999A, ref_mul(24'hCC_CCCD, 24'h9B_999A), "R10 same-cycle result");
        drive(24'h80_0000, 24'h80_0000, 48'h4000_0000_0000, "R3 minimum normalised square");

        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        report();
        $finish;
    end

endmodule